// File: doc/BRIEF.md
# Banked Memory Configuration Register File

This block is the byte-wide, processor-facing register set of a banking memory controller. It holds the live bank configuration, four preset configurations, a mode register, a RAM-sharing register, two relocatable page pointers and a read-only version byte. Every stored value is exported on parallel ports to the address-translation logic, which lies outside this block.

The registers are reached through two windows. The main window is a 256-byte page in the I/O area. It answers only while bit 0 of the live configuration is 0. A five-byte window near the top of the address space answers in every configuration. In that small window, offset 0 is the live configuration. A write to offsets 1 to 4 copies the matching preset into the live configuration in one cycle, whatever data is written. Each page pointer has a staged high byte that takes effect only when its low byte is written. Setting the hide bit in the mode register removes both windows from the map until the next reset.

Reads are combinational from the address. Writes take effect at the rising clock edge on which `cpu_wr` is high. An address that no window claims reads 0xFF with `cpu_hit` low.

Top module: `bank_cfg_regs`

## Requirements
- R1: After reset the registers hold the following values. The live configuration is 0x00 and the share register is 0x00. Presets A, B, C and D are 0x3F, 0x7F, 0x01 and 0x41. Page-pointer low bytes are 0x00 (pointer 0) and 0x01 (pointer 1). Page-pointer high bytes read 0xF0. The mode register latches reset so that, with the key released and both cartridge lines high, mode reads 0xB7.
- R2: The live configuration is one storage location. It is reached at I/O offset 0 (address 0xD500) and at top offset 0 (address 0xFF00). Data written at either address reads back at both and appears on `cfg_o`.
- R3: Presets A to D are read and written at I/O offsets 1 to 4. They appear on `preset_o`, with A in bits 7:0 and D in bits 31:24.
- R4: Reading top offsets 1 to 4 (0xFF01 to 0xFF04) returns presets A to D. Writing any data to one of those addresses loads the matching preset into the live configuration at that clock edge.
- R5: Pointer 0 occupies I/O offsets 7 (low) and 8 (high). Pointer 1 occupies offsets 9 (low) and 10 (high). A write to a high offset only stages bits 3:0, and neither the read value nor `page_o` changes. A write to the low offset commits the low byte and the staged nibble together. `page_o` packs each pointer as {high nibble, low byte}, with pointer 0 in bits 11:0.
- R6: Bits 7:4 of a page-pointer high byte always read as 1. Bits 2:1 of the mode register always read as 1.
- R7: I/O offset 11 always reads 0x20, and writes to it change nothing.
- R8: I/O offsets 12 to 255 read 0xFF with `cpu_hit` high, and writes there change no register.
- R9: While `cfg_o` bit 0 is 1, the I/O window reads 0xFF with `cpu_hit` low and ignores writes. The top window keeps answering.
- R10: Writing mode bit 6 as 1 sets `hidden_o`. From then until reset, neither window answers: `cpu_hit` is low, reads give 0xFF and all writes are ignored.
- R11: Mode bit 7 reads as `key_n_in` (1 = released) AND a latch. The latch resets to 1, and writing bit 7 as 0 clears it. Once cleared, bit 7 reads 0 whatever the key does or later writes say.
- R12: The mode register is at I/O offset 5. Bit 0 drives `cpu_sel_o` (1 = main processor) and bit 3 drives `fast_dir_o`. Bits 5:4 are latches driven on `cart_drv_o`. Each of these bits reads back as the matching `cart_line_in` bit AND its latch.
- R13: The share register at I/O offset 6 stores all 8 written bits, reads them back and drives `share_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Bus address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (0xFF when not claimed) |
| cpu_hit | output | 1 | The address is claimed by a window |
| key_n_in | input | 1 | Display-mode key, 0 = pressed |
| cart_line_in | input | 2 | Sensed cartridge lines |
| cfg_o | output | 8 | Live configuration |
| preset_o | output | 32 | Presets A..D |
| share_o | output | 8 | RAM-sharing register |
| page_o | output | 24 | Page pointers {hi nibble, lo byte} x2 |
| cpu_sel_o | output | 1 | Processor select |
| fast_dir_o | output | 1 | Fast-serial direction |
| cart_drv_o | output | 2 | Cartridge line latches |
| hidden_o | output | 1 | Register windows removed from map |

## Verification
The hardest states to reach are the ones that cut off access to the block itself. Turning on live-configuration bit 0 closes the I/O window, so the bench reopens it only through the top window. Setting the hide bit closes both windows, so the bench leaves it for last and ends with a reset. The staged pointer nibble is invisible until the low byte is written. The bench therefore checks each pointer's read value and `page_o` between the high write and the low write, and it sweeps all sixteen nibbles.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef struct packed {
    logic       hit;
    logic       io;
    logic [7:0] off;
  } bcr_sel_t;

  typedef struct packed {
    logic       key_lat;
    logic       hide;
    logic [1:0] cart_lat;
    logic       dir;
    logic       cpu;
  } bcr_mode_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [3:0] HI_PAD    = 4'hF;
  localparam bcr_mode_t  MODE_RST  = '{key_lat: 1'b1, hide: 1'b0,
                                      cart_lat: 2'b11, dir: 1'b0, cpu: 1'b1};

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] IO_BASE  = 16'hD500,
  parameter logic [AW-1:0] TOP_BASE = 16'hFF00,
  parameter int            TOP_REGS = 5
) (
  input  logic [AW-1:0] addr_i,
  input  logic          io_on_i,
  input  logic          hidden_i,
  output bcr_sel_t      sel_o
);

  logic io_match;
  logic top_match;

  always_comb begin
    io_match  = (addr_i[AW-1:8] == IO_BASE[AW-1:8]);
    top_match = (addr_i[AW-1:8] == TOP_BASE[AW-1:8]) &&
                (addr_i[7:0] < 8'(TOP_REGS));
    sel_o.hit = !hidden_i && ((io_match && io_on_i) || top_match);
    sel_o.io  = io_match;
    sel_o.off = addr_i[7:0];
  end

endmodule

// File: rtl/bcr_pageptr.sv
module bcr_pageptr #(
  parameter logic [7:0] LO_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       lo_we_i,
  input  logic       hi_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] lo_o,
  output logic [3:0] hi_o
);

  logic [7:0] lo_q, lo_d;
  logic [3:0] hi_q, hi_d;
  logic [3:0] stg_q, stg_d;

  // staged nibble is committed together with the low byte
  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    stg_d = stg_q;
    if (hi_we_i) stg_d = wdata_i[3:0];
    if (lo_we_i) begin
      lo_d = wdata_i;
      hi_d = stg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= LO_RST;
      hi_q  <= 4'h0;
      stg_q <= 4'h0;
    end else begin
      if (lo_we_i) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
      if (hi_we_i) stg_q <= stg_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
  import bcr_pkg::*;
#(
  parameter int         NPRE      = 4,
  parameter int         NPTR      = 2,
  parameter int         OFF_MODE  = 5,
  parameter int         OFF_SHARE = 6,
  parameter int         OFF_PTR   = 7,
  parameter int         OFF_VER   = 11,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  bcr_sel_t            sel_i,
  input  logic [7:0]          cfg_i,
  input  logic [NPRE*8-1:0]   preset_i,
  input  logic [7:0]          mode_i,
  input  logic [7:0]          share_i,
  input  logic [NPTR*8-1:0]   lo_i,
  input  logic [NPTR*4-1:0]   hi_i,
  output logic [7:0]          rdata_o
);

  always_comb begin
    rdata_o = FILL_BYTE;
    if (sel_i.hit) begin
      if (sel_i.off == 8'd0) rdata_o = cfg_i;
      for (int k = 0; k < NPRE; k++)
        if (sel_i.off == 8'(k + 1)) rdata_o = preset_i[k*8 +: 8];
      if (sel_i.io) begin
        if (sel_i.off == 8'(OFF_MODE))  rdata_o = mode_i;
        if (sel_i.off == 8'(OFF_SHARE)) rdata_o = share_i;
        for (int p = 0; p < NPTR; p++) begin
          if (sel_i.off == 8'(OFF_PTR + 2*p))     rdata_o = lo_i[p*8 +: 8];
          if (sel_i.off == 8'(OFF_PTR + 2*p + 1)) rdata_o = {HI_PAD, hi_i[p*4 +: 4]};
        end
        if (sel_i.off == 8'(OFF_VER)) rdata_o = VERSION;
      end
    end
  end

endmodule

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bcr_pkg::*;
#(
  parameter int                 AW       = 16,
  parameter logic [AW-1:0]      IO_BASE  = 16'hD500,
  parameter logic [AW-1:0]      TOP_BASE = 16'hFF00,
  parameter int                 NPRE     = 4,
  parameter logic [NPRE*8-1:0]  PRE_RST  = 32'h41017F3F,
  parameter logic [7:0]         VERSION  = 8'h20,
  parameter int                 NPTR     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cpu_addr,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               cpu_hit,
  input  logic               key_n_in,
  input  logic [1:0]         cart_line_in,
  output logic [7:0]         cfg_o,
  output logic [NPRE*8-1:0]  preset_o,
  output logic [7:0]         share_o,
  output logic [NPTR*12-1:0] page_o,
  output logic               cpu_sel_o,
  output logic               fast_dir_o,
  output logic [1:0]         cart_drv_o,
  output logic               hidden_o
);

  localparam int TOP_REGS  = NPRE + 1;
  localparam int OFF_MODE  = NPRE + 1;
  localparam int OFF_SHARE = NPRE + 2;
  localparam int OFF_PTR   = NPRE + 3;
  localparam int OFF_VER   = OFF_PTR + 2*NPTR;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [7:0]        cfg_q, cfg_d;
  logic              cfg_en;
  logic [NPRE*8-1:0] pre_q, pre_d;
  logic              pre_en;
  bcr_mode_t         mode_q, mode_d;
  logic              mode_en;
  logic [7:0]        share_q, share_d;
  logic              share_en;
  logic [7:0]        mode_rd;
  logic [NPTR*8-1:0] ptr_lo;
  logic [NPTR*4-1:0] ptr_hi;

  bcr_sel_t sel;
  logic     wr_ok, wr_io, wr_top;

  bcr_decode #(
    .AW(AW), .IO_BASE(IO_BASE), .TOP_BASE(TOP_BASE), .TOP_REGS(TOP_REGS)
  ) u_dec (
    .addr_i   (cpu_addr),
    .io_on_i  (~cfg_q[0]),
    .hidden_i (mode_q.hide),
    .sel_o    (sel)
  );

  assign wr_ok  = cpu_wr & sel.hit;
  assign wr_io  = wr_ok & sel.io;
  assign wr_top = wr_ok & ~sel.io;

  // next-state logic
  always_comb begin
    cfg_d    = cfg_q;
    cfg_en   = 1'b0;
    pre_d    = pre_q;
    pre_en   = 1'b0;
    mode_d   = mode_q;
    mode_en  = 1'b0;
    share_d  = share_q;
    share_en = 1'b0;

    if (wr_ok && sel.off == 8'd0) begin
      cfg_en = 1'b1;
      cfg_d  = cpu_wdata;
    end
    for (int k = 0; k < NPRE; k++) begin
      if (wr_top && sel.off == 8'(k + 1)) begin
        cfg_en = 1'b1;
        cfg_d  = pre_q[k*8 +: 8];
      end
      if (wr_io && sel.off == 8'(k + 1)) begin
        pre_en          = 1'b1;
        pre_d[k*8 +: 8] = cpu_wdata;
      end
    end
    if (wr_io && sel.off == 8'(OFF_MODE)) begin
      mode_en         = 1'b1;
      mode_d.key_lat  = mode_q.key_lat & cpu_wdata[7];
      mode_d.hide     = mode_q.hide | cpu_wdata[6];
      mode_d.cart_lat = cpu_wdata[5:4];
      mode_d.dir      = cpu_wdata[3];
      mode_d.cpu      = cpu_wdata[0];
    end
    if (wr_io && sel.off == 8'(OFF_SHARE)) begin
      share_en = 1'b1;
      share_d  = cpu_wdata;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= 8'h00;
      pre_q   <= PRE_RST;
      mode_q  <= MODE_RST;
      share_q <= 8'h00;
    end else begin
      if (cfg_en)   cfg_q   <= cfg_d;
      if (pre_en)   pre_q   <= pre_d;
      if (mode_en)  mode_q  <= mode_d;
      if (share_en) share_q <= share_d;
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    bcr_pageptr #(.LO_RST(8'(p))) u_ptr (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .lo_we_i (wr_io && sel.off == 8'(OFF_PTR + 2*p)),
      .hi_we_i (wr_io && sel.off == 8'(OFF_PTR + 2*p + 1)),
      .wdata_i (cpu_wdata),
      .lo_o    (ptr_lo[p*8 +: 8]),
      .hi_o    (ptr_hi[p*4 +: 4])
    );
    assign page_o[p*12 +: 12] = {ptr_hi[p*4 +: 4], ptr_lo[p*8 +: 8]};
  end

  assign mode_rd = {key_n_in & mode_q.key_lat, mode_q.hide,
                    cart_line_in & mode_q.cart_lat, mode_q.dir,
                    2'b11, mode_q.cpu};

  bcr_rdmux #(
    .NPRE(NPRE), .NPTR(NPTR), .OFF_MODE(OFF_MODE), .OFF_SHARE(OFF_SHARE),
    .OFF_PTR(OFF_PTR), .OFF_VER(OFF_VER), .VERSION(VERSION)
  ) u_rd (
    .sel_i    (sel),
    .cfg_i    (cfg_q),
    .preset_i (pre_q),
    .mode_i   (mode_rd),
    .share_i  (share_q),
    .lo_i     (ptr_lo),
    .hi_i     (ptr_hi),
    .rdata_o  (cpu_rdata)
  );

  assign cpu_hit    = sel.hit;
  assign cfg_o      = cfg_q;
  assign preset_o   = pre_q;
  assign share_o    = share_q;
  assign cpu_sel_o  = mode_q.cpu;
  assign fast_dir_o = mode_q.dir;
  assign cart_drv_o = mode_q.cart_lat;
  assign hidden_o   = mode_q.hide;

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] IO_BASE  = 16'hD500,
  parameter logic [AW-1:0] TOP_BASE = 16'hFF00,
  parameter int            NPRE     = 4,
  parameter int            NPTR     = 2,
  parameter logic [7:0]    VERSION  = 8'h20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      cpu_addr,
  input logic               cpu_wr,
  input logic [7:0]         cpu_rdata,
  input logic               cpu_hit,
  input logic [7:0]         cfg_o,
  input logic [NPRE*8-1:0]  preset_o,
  input logic [NPTR*12-1:0] page_o,
  input logic               hidden_o
);

  p_hide_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_o |=> hidden_o);

  p_hide_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_o |-> (!cpu_hit && cpu_rdata == 8'hFF));

  p_io_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[0] && cpu_addr[AW-1:8] == IO_BASE[AW-1:8]) |-> !cpu_hit);

  p_shortcut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_hit && cpu_addr == (TOP_BASE + AW'(1))) |=>
      cfg_o == $past(preset_o[7:0]));

  p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_hit && cpu_addr == (IO_BASE + AW'(NPRE + 4))) |=>
      $stable(page_o));

  p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && cpu_addr == (IO_BASE + AW'(NPRE + 3 + 2*NPTR))) |->
      cpu_rdata == VERSION);

endmodule

bind bank_cfg_regs bcr_checker #(
  .AW(AW), .IO_BASE(IO_BASE), .TOP_BASE(TOP_BASE),
  .NPRE(NPRE), .NPTR(NPTR), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cfg_o(cfg_o),
  .preset_o(preset_o), .page_o(page_o), .hidden_o(hidden_o)
);

// File: tb/bank_cfg_regs_test.sv
`timescale 1ns/1ps
module bank_cfg_regs_test;

  localparam logic [15:0] IO  = 16'hD500;
  localparam logic [15:0] TOP = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_hit;
  logic        key_n_in;
  logic [1:0]  cart_line_in;
  logic [7:0]  cfg_o;
  logic [31:0] preset_o;
  logic [7:0]  share_o;
  logic [23:0] page_o;
  logic        cpu_sel_o, fast_dir_o, hidden_o;
  logic [1:0]  cart_drv_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bank_cfg_regs uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #0.5;
    d = cpu_rdata; h = cpu_hit;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(100000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       h;
    logic [7:0] pre_exp [4];
    cpu_addr = '0; cpu_wr = 0; cpu_wdata = 0;
    key_n_in = 1'b1; cart_line_in = 2'b11;
    do_reset();

    // R1 reset values
    rd(TOP, d, h);      chk("R1 cfg", d, 8'h00);
    rd(IO + 1, d, h);   chk("R1 preset A", d, 8'h3F);
    rd(IO + 2, d, h);   chk("R1 preset B", d, 8'h7F);
    rd(IO + 3, d, h);   chk("R1 preset C", d, 8'h01);
    rd(IO + 4, d, h);   chk("R1 preset D", d, 8'h41);
    rd(IO + 5, d, h);   chk("R1 mode", d, 8'hB7);
    rd(IO + 6, d, h);   chk("R1 share", d, 8'h00);
    rd(IO + 7, d, h);   chk("R1 p0 lo", d, 8'h00);
    rd(IO + 8, d, h);   chk("R1 p0 hi", d, 8'hF0);
    rd(IO + 9, d, h);   chk("R1 p1 lo", d, 8'h01);
    rd(IO + 10, d, h);  chk("R1 p1 hi", d, 8'hF0);
    chk("R1 page_o", page_o, 24'h001000);

    // R2 / R9 live configuration through both windows
    for (int v = 0; v < 256; v++) begin
      wr(TOP, 8'(v));
      rd(TOP, d, h);     chk("R2 top read", d, v);
      chk("R2 cfg_o", cfg_o, v);
      rd(IO, d, h);
      if (v % 2 == 0) begin
        chk("R2 io read", d, v);
      end else begin
        chk("R9 io closed hit", h, 0);
        chk("R9 io closed data", d, 8'hFF);
        wr(IO + 6, 8'h77);
        chk("R9 write ignored", share_o, 8'h00);
      end
      wr(TOP, 8'h00);
      wr(IO, 8'(v & 8'hFE));
      rd(TOP, d, h);     chk("R2 io write seen at top", d, v & 8'hFE);
    end
    wr(TOP, 8'h00);

    // R3 presets
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 256; v++) begin
        wr(IO + 16'(k + 1), 8'(v));
        rd(IO + 16'(k + 1), d, h);  chk("R3 preset io", d, v);
        rd(TOP + 16'(k + 1), d, h); chk("R4 preset top read", d, v);
        chk("R3 preset_o", preset_o[k*8 +: 8], v);
      end

    // R4 shortcut load ignores data
    pre_exp = '{8'h22, 8'h44, 8'h66, 8'h88};
    for (int k = 0; k < 4; k++) wr(IO + 16'(k + 1), pre_exp[k]);
    for (int k = 0; k < 4; k++) begin
      wr(TOP + 16'(k + 1), 8'(k * 53 + 1));
      chk("R4 shortcut cfg_o", cfg_o, pre_exp[k]);
      rd(TOP, d, h); chk("R4 shortcut read", d, pre_exp[k]);
    end
    wr(TOP, 8'h00);

    // R5 / R6 page pointer staging
    wr(IO + 8, 8'h05);
    rd(IO + 8, d, h);  chk("R5 hi held", d, 8'hF0);
    chk("R5 page0 held", page_o[11:0], 12'h000);
    wr(IO + 7, 8'h9C);
    rd(IO + 8, d, h);  chk("R5 hi commit", d, 8'hF5);
    rd(IO + 7, d, h);  chk("R5 lo commit", d, 8'h9C);
    chk("R5 page0", page_o[11:0], 12'h59C);
    wr(IO + 10, 8'h0A);
    chk("R5 page1 held", page_o[23:12], 12'h001);
    wr(IO + 9, 8'h33);
    chk("R5 page1", page_o[23:12], 12'hA33);
    for (int hh = 0; hh < 16; hh++) begin
      wr(IO + 10, 8'(((15 - hh) << 4) | hh));
      rd(IO + 10, d, h); chk("R5 staged not visible", d, 8'hFA);
      wr(IO + 9, 8'(hh * 16));
      rd(IO + 10, d, h); chk("R6 hi pad", d, 8'hF0 | hh);
      chk("R5 page1 sweep", page_o[23:12], (hh << 8) | (hh * 16));
      wr(IO + 10, 8'h0A);
      wr(IO + 9, 8'h33);
    end

    // R7 version
    wr(IO + 11, 8'h55);
    rd(IO + 11, d, h); chk("R7 version", d, 8'h20);

    // R13 share
    for (int v = 0; v < 256; v++) begin
      wr(IO + 6, 8'(v));
      rd(IO + 6, d, h); chk("R13 share read", d, v);
      chk("R13 share_o", share_o, v);
    end
    wr(IO + 6, 8'h5A);

    // R8 unused offsets
    for (int o = 12; o < 256; o++) begin
      wr(IO + 16'(o), 8'h00);
      rd(IO + 16'(o), d, h);
      chk("R8 unused data", d, 8'hFF);
      chk("R8 unused hit", h, 1);
    end
    chk("R8 share kept", share_o, 8'h5A);
    chk("R8 cfg kept", cfg_o, 8'h00);
    chk("R8 page kept", page_o, 24'hA3359C);

    // R12 / R6 mode fields
    wr(IO + 5, 8'h89);
    chk("R12 cpu_sel", cpu_sel_o, 1);
    chk("R12 fast_dir", fast_dir_o, 1);
    chk("R12 cart_drv", cart_drv_o, 2'b00);
    rd(IO + 5, d, h); chk("R12 mode read", d, 8'h8F);
    wr(IO + 5, 8'hB0);
    cart_line_in = 2'b10;
    rd(IO + 5, d, h); chk("R12 cart mirror", d, 8'hA6);
    chk("R12 cpu_sel alt", cpu_sel_o, 0);
    cart_line_in = 2'b11;

    // R11 key bit
    key_n_in = 1'b0;
    rd(IO + 5, d, h); chk("R11 key pressed", d[7], 0);
    key_n_in = 1'b1;
    rd(IO + 5, d, h); chk("R11 key released", d[7], 1);
    wr(IO + 5, 8'h30);
    rd(IO + 5, d, h); chk("R11 cleared", d[7], 0);
    wr(IO + 5, 8'hB0);
    rd(IO + 5, d, h); chk("R11 stays cleared", d[7], 0);
    chk("R6 mode pad", d[2:1], 2'b11);

    // R10 hide
    wr(IO + 5, 8'h70);
    chk("R10 hidden_o", hidden_o, 1);
    rd(TOP, d, h);    chk("R10 top hit", h, 0); chk("R10 top data", d, 8'hFF);
    rd(IO + 6, d, h); chk("R10 io hit", h, 0);  chk("R10 io data", d, 8'hFF);
    wr(TOP + 1, 8'h00);
    chk("R10 shortcut ignored", cfg_o, 8'h00);
    wr(IO + 6, 8'h11);
    chk("R10 write ignored", share_o, 8'h5A);
    do_reset();
    chk("R10 reset clears", hidden_o, 0);
    rd(TOP, d, h); chk("R10 top back", h, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule